// File: doc/BRIEF.md
# Predicated Vector Integer Binary ALU

This block runs one predicated, two-operand integer vector instruction over a 128-bit granule. The caller gives a 32-bit instruction word, the first and second source vectors, the current contents of the destination and a governing predicate with one bit per byte. The block decodes the instruction and applies the chosen operation lane by lane. Lanes are bytes, halfwords, words or doublewords. Only active lanes are written. Every other lane keeps its old destination value.

The bitwise, additive and min/max/difference operations and the multiplies finish in a fixed short time. Divides run a bit-serial loop whose length equals the element width. Inputs are captured when `start` is accepted, so the caller may change them while the block is busy. Completion is a single-cycle `done` pulse. `result` and `undef` are updated at that pulse and held until the next one. Register numbers in the instruction word are not used, because register file access happens outside this block.

Top module: `pvec_alu`

## Requirements
- R1: Instruction fields: bits [31:24] must equal 0x04 and bits [15:13] must equal 0. Bits [23:22] give the element size (0 byte, 1 halfword, 2 word, 3 doubleword), bits [21:19] the group and bits [18:16] the operation. A word with either fixed field wrong completes with `undef`=1 and `result` equal to the captured destination.
- R2: Group 3 is logical: op 0 OR, op 1 XOR, op 2 AND, op 3 n AND NOT m.
- R3: Group 0: op 0 computes n+m, op 1 computes n-m and op 3 computes m-n. All wrap modulo the element width.
- R4: Group 1 picks between n and m: op 0 signed max, op 1 unsigned max, op 2 signed min, op 3 unsigned min. Op 4 gives the signed absolute difference and op 5 the unsigned absolute difference (larger minus smaller).
- R5: Group 2 multiplies: op 0 gives the low half of the product, op 2 the high half of the signed double-width product, and op 3 the high half of the unsigned one.
- R6: Group 2 divides: op 4 signed n/m, op 5 unsigned n/m, op 6 signed m/n, op 7 unsigned m/n. Quotients truncate toward zero, a zero divisor yields 0, and the most negative value divided by -1 yields the most negative value.
- R7: A divide (group 2, op 4 to 7) with element size 0 or 1 completes with `undef`=1 and the destination unchanged.
- R8: Unlisted encodings complete with `undef`=1 and the destination unchanged. These are group 0 ops 2 and 4 to 7, group 1 ops 6 and 7, group 2 op 1, group 3 ops 4 to 7, and groups 4 to 7.
- R9: A lane of size E at index i is active when predicate bit i*2^E is 1. The other predicate bits covering the lane have no effect.
- R10: Inactive lanes of an accepted, defined instruction return the captured destination value (merging).
- R11: After reset, `result`, `done` and `undef` are 0. Each accepted `start` gives exactly one `done` pulse lasting one cycle. `start` is ignored while an operation is in flight, and inputs are captured when `start` is accepted. `result` and `undef` change only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| insn | input | 32 | Instruction word |
| opnd_n | input | 128 | First source vector |
| opnd_m | input | 128 | Second source vector |
| dest_old | input | 128 | Current destination contents |
| pred | input | 16 | Governing predicate, one bit per byte |
| result | output | 128 | Merged result vector |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Instruction was undefined; result is the old destination |

## Verification
Some internal faults show at the very next `done`, two cycles after an ALU start or about one element width later for a divide. A stale capture register, a wrong lane-activity mask or a mis-decoded size is one such fault: the block then returns wrong lane values or leaks old destination bytes into active lanes. Some divider faults appear only in particular lanes. A bad iteration count, a missing sign fix-up or a missing zero-divisor path gives wrong quotients only where the sign, the width or a zero divisor is involved. Corner operands are therefore mixed into the random traffic. A control fault that lets `start` through while busy shows as an extra `done` or as a result computed from the wrong inputs.

// File: rtl/pvec_pkg.sv
package pvec_pkg;

   typedef enum logic [3:0] {
      OP_ORR, OP_EOR, OP_AND, OP_BIC,
      OP_ADD, OP_SUB,
      OP_SMAX, OP_UMAX, OP_SMIN, OP_UMIN, OP_SABD, OP_UABD,
      OP_MUL, OP_SMULH, OP_UMULH,
      OP_DIV
   } op_e;

   typedef struct packed {
      logic       valid;
      op_e        op;
      logic       swap;
      logic [1:0] esz;
      logic       is_div;
      logic       div_sgn;
   } dec_t;

endpackage

// File: rtl/pvec_decode.sv
module pvec_decode
   import pvec_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        dec
);
   logic [2:0] grp, opc;
   logic       fixed_ok;

   assign grp      = insn[21:19];
   assign opc      = insn[18:16];
   assign fixed_ok = (insn[31:24] == 8'h04) && (insn[15:13] == 3'b000);

   always_comb begin
      dec         = '0;
      dec.esz     = insn[23:22];
      dec.op      = OP_ORR;
      dec.valid   = 1'b0;
      unique case (grp)
         3'b011: begin
            dec.valid = (opc[2] == 1'b0);
            unique case (opc[1:0])
               2'd0: dec.op = OP_ORR;
               2'd1: dec.op = OP_EOR;
               2'd2: dec.op = OP_AND;
               default: dec.op = OP_BIC;
            endcase
         end
         3'b000: begin
            dec.valid = (opc == 3'd0) || (opc == 3'd1) || (opc == 3'd3);
            dec.op    = (opc == 3'd0) ? OP_ADD : OP_SUB;
            dec.swap  = (opc == 3'd3);
         end
         3'b001: begin
            dec.valid = (opc <= 3'd5);
            unique case (opc)
               3'd0: dec.op = OP_SMAX;
               3'd1: dec.op = OP_UMAX;
               3'd2: dec.op = OP_SMIN;
               3'd3: dec.op = OP_UMIN;
               3'd4: dec.op = OP_SABD;
               default: dec.op = OP_UABD;
            endcase
         end
         3'b010: begin
            if (opc[2]) begin
               dec.op      = OP_DIV;
               dec.is_div  = 1'b1;
               dec.div_sgn = ~opc[0];
               dec.swap    = opc[1];
               dec.valid   = insn[23];
            end else begin
               dec.valid = (opc != 3'd1);
               unique case (opc[1:0])
                  2'd0: dec.op = OP_MUL;
                  2'd2: dec.op = OP_SMULH;
                  default: dec.op = OP_UMULH;
               endcase
            end
         end
         default: dec.valid = 1'b0;
      endcase
      dec.valid = dec.valid & fixed_ok;
   end
endmodule

// File: rtl/pvec_lane.sv
module pvec_lane
   import pvec_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  op_e          op,
   output logic [W-1:0] y
);
   localparam int PW = 2 * W;

   logic          ext_s;
   logic [PW-1:0] xa, xb, prod;
   logic          lt_s, lt_u;

   assign ext_s = (op == OP_SMULH);
   assign xa    = {{W{ext_s & a[W-1]}}, a};
   assign xb    = {{W{ext_s & b[W-1]}}, b};
   assign prod  = xa * xb;
   assign lt_s  = $signed(a) < $signed(b);
   assign lt_u  = a < b;

   always_comb begin
      unique case (op)
         OP_ORR:   y = a | b;
         OP_EOR:   y = a ^ b;
         OP_AND:   y = a & b;
         OP_BIC:   y = a & ~b;
         OP_ADD:   y = a + b;
         OP_SUB:   y = a - b;
         OP_SMAX:  y = lt_s ? b : a;
         OP_UMAX:  y = lt_u ? b : a;
         OP_SMIN:  y = lt_s ? a : b;
         OP_UMIN:  y = lt_u ? a : b;
         OP_SABD:  y = lt_s ? (b - a) : (a - b);
         OP_UABD:  y = lt_u ? (b - a) : (a - b);
         OP_MUL:   y = prod[W-1:0];
         OP_SMULH,
         OP_UMULH: y = prod[PW-1:W];
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/pvec_div.sv
module pvec_div #(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          wide,
   input  logic          sgn,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] q
);
   localparam int HW = DW / 2;

   logic [DW:0]   rem_q;
   logic [DW-1:0] dvd_q, dsr_q, quo_q;
   logic          neg_q, bz_q;
   logic [DW-1:0] mag_a, mag_b;
   logic [DW:0]   trial;
   logic          fits;

   assign mag_a = (sgn && a[DW-1]) ? (~a + 1'b1) : a;
   assign mag_b = (sgn && b[DW-1]) ? (~b + 1'b1) : b;
   assign trial = {rem_q[DW-1:0], dvd_q[DW-1]};
   assign fits  = (trial >= {1'b0, dsr_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvd_q <= '0;
         dsr_q <= '0;
         quo_q <= '0;
         neg_q <= 1'b0;
         bz_q  <= 1'b0;
      end else if (load) begin
         rem_q <= '0;
         quo_q <= '0;
         dsr_q <= mag_b;
         dvd_q <= wide ? mag_a : {mag_a[HW-1:0], {HW{1'b0}}};
         neg_q <= sgn & (a[DW-1] ^ b[DW-1]);
         bz_q  <= (b == '0);
      end else if (step) begin
         rem_q <= fits ? (trial - {1'b0, dsr_q}) : trial;
         dvd_q <= {dvd_q[DW-2:0], 1'b0};
         quo_q <= {quo_q[DW-2:0], fits};
      end
   end

   assign q = bz_q ? '0 : (neg_q ? (~quo_q + 1'b1) : quo_q);
endmodule

// File: rtl/pvec_alu.sv
module pvec_alu
   import pvec_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [31:0]        insn,
   input  logic [VEC_W-1:0]   opnd_n,
   input  logic [VEC_W-1:0]   opnd_m,
   input  logic [VEC_W-1:0]   dest_old,
   input  logic [VEC_W/8-1:0] pred,
   output logic [VEC_W-1:0]   result,
   output logic               done,
   output logic               undef
);
   localparam int NB    = VEC_W / 8;
   localparam int NSLOT = VEC_W / 32;
   localparam int NDW   = VEC_W / 64;

   if (VEC_W % 64 != 0 || VEC_W < 64) begin : g_bad_width
      $error("pvec_alu: VEC_W must be a positive multiple of 64");
   end

   typedef enum logic [2:0] {S_IDLE, S_ALU, S_DLOAD, S_DIV, S_FIN} state_e;

   state_e           state_q;
   dec_t             dec, cap_dec;
   logic [VEC_W-1:0] cap_n, cap_m, cap_d;
   logic [NB-1:0]    cap_p;
   logic [6:0]       cnt_q;
   logic             div_load, div_step;

   pvec_decode u_dec (.insn(insn), .dec(dec));

   // ALU lanes for every element size
   logic [VEC_W-1:0] alu_vec [4];

   for (genvar s = 0; s < 4; s++) begin : g_size
      localparam int W  = 8 << s;
      localparam int NL = VEC_W / W;
      for (genvar l = 0; l < NL; l++) begin : g_lane
         pvec_lane #(.W(W)) u_lane (
            .a  (cap_n[l*W +: W]),
            .b  (cap_m[l*W +: W]),
            .op (cap_dec.op),
            .y  (alu_vec[s][l*W +: W])
         );
      end
   end

   // Division slots: one per word lane, the low ones double as doubleword lanes
   logic [VEC_W-1:0] div_wvec, div_dvec;
   logic             wide;
   assign wide = (cap_dec.esz == 2'd3);

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      logic [63:0] sa, sb, sq;
      logic [31:0] wa, wb;
      assign wa = cap_n[32*k +: 32];
      assign wb = cap_m[32*k +: 32];
      if (k < NDW) begin : g_dw
         assign sa = wide ? cap_n[64*k +: 64] : {{32{cap_dec.div_sgn & wa[31]}}, wa};
         assign sb = wide ? cap_m[64*k +: 64] : {{32{cap_dec.div_sgn & wb[31]}}, wb};
         assign div_dvec[64*k +: 64] = sq;
      end else begin : g_w
         assign sa = {{32{cap_dec.div_sgn & wa[31]}}, wa};
         assign sb = {{32{cap_dec.div_sgn & wb[31]}}, wb};
      end
      pvec_div #(.DW(64)) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (div_load),
         .step  (div_step),
         .wide  (wide),
         .sgn   (cap_dec.div_sgn),
         .a     (sa),
         .b     (sb),
         .q     (sq)
      );
      assign div_wvec[32*k +: 32] = sq[31:0];
   end

   // Lane activity, expanded to bytes from each lane's lowest predicate bit
   logic [NB-1:0]    act_b;
   logic [VEC_W-1:0] act_bits, pick, merged;

   always_comb begin
      for (int j = 0; j < NB; j++) begin
         act_b[j] = cap_p[j & ~((1 << cap_dec.esz) - 1)];
         act_bits[j*8 +: 8] = {8{act_b[j]}};
      end
   end

   assign pick   = cap_dec.is_div ? (wide ? div_dvec : div_wvec) : alu_vec[cap_dec.esz];
   assign merged = (pick & act_bits) | (cap_d & ~act_bits);

   assign div_load = (state_q == S_DLOAD);
   assign div_step = (state_q == S_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cap_dec <= '0;
         cap_n   <= '0;
         cap_m   <= '0;
         cap_d   <= '0;
         cap_p   <= '0;
         cnt_q   <= '0;
         result  <= '0;
         done    <= 1'b0;
         undef   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            S_IDLE: if (start) begin
               cap_dec <= dec;
               cap_n   <= dec.swap ? opnd_m : opnd_n;
               cap_m   <= dec.swap ? opnd_n : opnd_m;
               cap_d   <= dest_old;
               cap_p   <= pred;
               state_q <= (dec.valid && dec.is_div) ? S_DLOAD : S_ALU;
            end
            S_ALU: begin
               result  <= cap_dec.valid ? merged : cap_d;
               undef   <= ~cap_dec.valid;
               done    <= 1'b1;
               state_q <= S_IDLE;
            end
            S_DLOAD: begin
               cnt_q   <= wide ? 7'd64 : 7'd32;
               state_q <= S_DIV;
            end
            S_DIV: begin
               cnt_q <= cnt_q - 7'd1;
               if (cnt_q == 7'd1) state_q <= S_FIN;
            end
            S_FIN: begin
               result  <= merged;
               undef   <= 1'b0;
               done    <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pvec_alu_chk.sv
module pvec_alu_chk #(
   parameter int VEC_W = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [31:0]        insn,
   input logic [VEC_W-1:0]   dest_old,
   input logic [VEC_W/8-1:0] pred,
   input logic [VEC_W-1:0]   result,
   input logic               done,
   input logic               undef
);
   localparam int NB = VEC_W / 8;

   logic             pending;
   logic [VEC_W-1:0] sv_d, inact;
   logic [NB-1:0]    sv_p;
   logic [1:0]       sv_esz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         sv_d    <= '0;
         sv_p    <= '0;
         sv_esz  <= '0;
      end else if (start && (!pending || done)) begin
         pending <= 1'b1;
         sv_d    <= dest_old;
         sv_p    <= pred;
         sv_esz  <= insn[23:22];
      end else if (done) begin
         pending <= 1'b0;
      end
   end

   always_comb begin
      for (int j = 0; j < NB; j++)
         inact[j*8 +: 8] = {8{~sv_p[j & ~((1 << sv_esz) - 1)]}};
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pending);
   assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
   assert_undef_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(undef) |-> done);
   assert_undef_keeps_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && undef) |-> (result == sv_d));
   assert_inactive_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (((result ^ sv_d) & inact) == '0));
endmodule

bind pvec_alu pvec_alu_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .dest_old(dest_old),
   .pred(pred), .result(result), .done(done), .undef(undef)
);

// File: tb/pvec_alu_tb.sv
`timescale 1ns/1ps
module pvec_alu_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] opnd_n = '0, opnd_m = '0, dest_old = '0;
   logic [15:0]  pred = '0;
   logic [127:0] result;
   logic         done, undef;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   pvec_alu u_dut (.*);

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit ref_valid(input logic [31:0] iw);
      logic [2:0] g, o;
      g = iw[21:19]; o = iw[18:16];
      if (iw[31:24] != 8'h04 || iw[15:13] != 3'b000) return 0;
      case (g)
         3'b011: return o <= 3;
         3'b000: return o == 0 || o == 1 || o == 3;
         3'b001: return o <= 5;
         3'b010: return o != 1 && (o < 4 || iw[23]);
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] ref_elem(input logic [2:0] g, input logic [2:0] o,
                                            input int w, input logic [63:0] x0, input logic [63:0] y0);
      logic [63:0] msk, x, y, t;
      logic signed [127:0] sx, sy, r;
      logic [127:0] ux, uy;
      msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
      x = x0 & msk; y = y0 & msk;
      if ((g == 3'b000 && o == 3) || (g == 3'b010 && o >= 6)) begin
         t = x; x = y; y = t;
      end
      ux = {64'd0, x}; uy = {64'd0, y};
      sx = $signed({x, 64'd0}) <<< (64 - w); sx = sx >>> (128 - w);
      sy = $signed({y, 64'd0}) <<< (64 - w); sy = sy >>> (128 - w);
      r = '0;
      case (g)
         3'b011: case (o) 0: r = ux | uy; 1: r = ux ^ uy; 2: r = ux & uy; default: r = ux & ~uy; endcase
         3'b000: r = (o == 0) ? ux + uy : ux - uy;
         3'b001: case (o)
            0: r = (sx >= sy) ? sx : sy;
            1: r = (ux >= uy) ? ux : uy;
            2: r = (sx >= sy) ? sy : sx;
            3: r = (ux >= uy) ? uy : ux;
            4: r = (sx >= sy) ? sx - sy : sy - sx;
            default: r = (ux >= uy) ? ux - uy : uy - ux;
         endcase
         default: case (o)
            0: r = ux * uy;
            2: r = (sx * sy) >>> w;
            3: r = (ux * uy) >> w;
            4, 6: r = (sy == 0) ? 0 : sx / sy;
            default: r = (uy == 0) ? 0 : ux / uy;
         endcase
      endcase
      return r[63:0] & msk;
   endfunction

   function automatic logic [127:0] ref_vec(input logic [31:0] iw, input logic [127:0] n,
                                            input logic [127:0] m, input logic [127:0] d, input logic [15:0] p);
      logic [127:0] v;
      int e, w;
      v = d;
      if (!ref_valid(iw)) return d;
      e = int'(iw[23:22]); w = 8 << e;
      for (int i = 0; i < (16 >> e); i++) begin
         if (p[i << e]) begin
            logic [63:0] r;
            r = ref_elem(iw[21:19], iw[18:16], w, 64'(n >> (i*w)), 64'(m >> (i*w)));
            for (int b = 0; b < w; b++) v[i*w + b] = r[b];
         end
      end
      return v;
   endfunction

   function automatic logic [31:0] mk(input logic [1:0] esz, input logic [2:0] g, input logic [2:0] o);
      return {8'h04, esz, g, o, 3'b000, 3'($urandom), 5'($urandom), 5'($urandom)};
   endfunction

   task automatic issue(input logic [31:0] iw, input logic [127:0] n, input logic [127:0] m,
                        input logic [127:0] d, input logic [15:0] p);
      @(negedge clk);
      insn = iw; opnd_n = n; opnd_m = m; dest_old = d; pred = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int g = 0;
      while (!done && g < 200) begin @(negedge clk); g++; end
   endtask

   task automatic run(input logic [31:0] iw, input logic [127:0] n, input logic [127:0] m,
                      input logic [127:0] d, input logic [15:0] p, input string tag);
      logic [127:0] ev;
      ev = ref_vec(iw, n, m, d, p);
      issue(iw, n, m, d, p);
      wait_done();
      chk(done === 1'b1, {tag, " done"}, {127'd0, done}, 128'd1);
      chk(result === ev, tag, result, ev);
      chk(undef === !ref_valid(iw), {tag, " undef"}, {127'd0, undef}, {127'd0, !ref_valid(iw)});
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(8ns * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] gs [16] = '{3'd3,3'd3,3'd3,3'd3,3'd0,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1,3'd1,3'd1,3'd2,3'd2,3'd2};
      logic [2:0] os [16] = '{3'd0,3'd1,3'd2,3'd3,3'd0,3'd1,3'd3,3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd0,3'd2,3'd3};
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(result === '0 && done === 1'b0 && undef === 1'b0, "R11 reset", result, '0);
      rst_n = 1'b1;

      // Directed: R2 logical, R3 reverse subtract, R4, R5 at several sizes
      run({8'h04, 2'd0, 3'd3, 3'd3, 3'd0, 13'd0}, {16{8'hF0}}, {16{8'h3C}}, '0, 16'hFFFF, "R2 bic bytes");
      run({8'h04, 2'd1, 3'd0, 3'd3, 3'd0, 13'd0}, {8{16'd5}}, {8{16'd3}}, '0, 16'hFFFF, "R3 subr half");
      run({8'h04, 2'd2, 3'd1, 3'd4, 3'd0, 13'd0}, {4{32'hFFFF_FFFE}}, {4{32'd3}}, '0, 16'hFFFF, "R4 sabd word");
      run({8'h04, 2'd3, 3'd2, 3'd2, 3'd0, 13'd0}, {2{64'h8000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}}, '0, 16'hFFFF, "R5 smulh dword");
      run({8'h04, 2'd3, 3'd2, 3'd3, 3'd0, 13'd0}, '1, '1, '0, 16'hFFFF, "R5 umulh dword");
      // R6 divide corners: zero divisor, min by -1, reversed
      run({8'h04, 2'd2, 3'd2, 3'd4, 3'd0, 13'd0}, {32'h8000_0000, 32'd7, 32'd100, 32'hFFFF_FFF9},
          {32'hFFFF_FFFF, 32'd0, 32'd7, 32'd2}, '0, 16'hFFFF, "R6 sdiv word corners");
      run({8'h04, 2'd3, 3'd2, 3'd4, 3'd0, 13'd0}, {64'h8000_0000_0000_0000, 64'd9},
          {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, '0, 16'hFFFF, "R6 sdiv dword corners");
      run({8'h04, 2'd2, 3'd2, 3'd7, 3'd0, 13'd0}, {4{32'd3}}, {4{32'd100}}, '0, 16'hFFFF, "R6 udivr word");
      // R7 divide at narrow sizes
      run({8'h04, 2'd0, 3'd2, 3'd5, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R7 udiv byte");
      run({8'h04, 2'd1, 3'd2, 3'd6, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R7 sdivr half");
      // R8 unlisted encodings, R1 fixed fields
      run({8'h04, 2'd2, 3'd2, 3'd1, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R8 grp2 op1");
      run({8'h04, 2'd0, 3'd1, 3'd6, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R8 grp1 op6");
      run({8'h04, 2'd0, 3'd5, 3'd0, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R8 grp5");
      run({8'h05, 2'd0, 3'd0, 3'd0, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R1 bad top");
      run({8'h04, 2'd0, 3'd0, 3'd0, 3'd5, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R1 bad mid");
      // R9: only non-lowest predicate bits set, so no lane is active; R10 merge
      run({8'h04, 2'd3, 3'd0, 3'd0, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hFEFE, "R9 dword upper bits");
      run({8'h04, 2'd2, 3'd0, 3'd0, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'h0E01, "R9 word lowest bit");
      run({8'h04, 2'd0, 3'd3, 3'd1, 3'd0, 13'd0}, rnd128(), rnd128(), rnd128(), 16'hA5C3, "R10 byte merge");

      // R11: start during busy ignored, inputs captured at start
      begin
         logic [31:0]  iw;
         logic [127:0] n, m, d, ev;
         int nd;
         iw = {8'h04, 2'd3, 3'd2, 3'd5, 3'd0, 13'd0};
         n = rnd128(); m = {64'd7, 64'd3}; d = rnd128();
         ev = ref_vec(iw, n, m, d, 16'hFFFF);
         issue(iw, n, m, d, 16'hFFFF);
         opnd_n = '0; opnd_m = '0; dest_old = '0; insn = {8'h04, 2'd0, 3'd3, 3'd0, 3'd0, 13'd0};
         repeat (5) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
         wait_done();
         chk(result === ev, "R11 busy start ignored, inputs captured", result, ev);
         nd = 0;
         repeat (20) begin @(negedge clk); if (done) nd++; end
         chk(nd == 0, "R11 single done", 128'(nd), 128'd0);
      end

      // Constrained random traffic covering R2..R10
      for (int it = 0; it < 400; it++) begin
         logic [31:0]  iw;
         logic [127:0] n, m;
         int k;
         k = int'($urandom_range(0, 19));
         if (k < 16) iw = mk(2'($urandom), gs[k], os[k]);
         else if (k < 19) iw = mk(2'($urandom_range(2, 3)), 3'd2, 3'($urandom_range(4, 7)));
         else iw = $urandom;
         n = rnd128(); m = rnd128();
         if ($urandom_range(0, 3) == 0) m = m & {16{8'($urandom_range(0, 1) ? 8'hFF : 8'h00)}};
         if ($urandom_range(0, 5) == 0) n = {4{32'h8000_0000}};
         if ($urandom_range(0, 5) == 0) m = '1;
         run(iw, n, m, rnd128(), 16'($urandom), "R2-R10 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule